// File: doc/BRIEF.md
# Multiplexed External Data Memory Sequencer

This block carries out byte-wide data-memory loads and stores for a small CPU core. A request arrives with a read/write flag, an addressing mode and a byte of write data. The address comes from one of two sources. In register-indirect mode it is an 8-bit index. In pointer mode it is the 16-bit data pointer that is currently selected. The block decides where the access goes. It either hands the access to the on-chip data RAM, through a simple enable/write-enable/address port, or runs a cycle on a multiplexed external bus. That bus has a shared low address/data byte, a high-address byte, an address-latch strobe and active-low read and write strobes. Each access ends with a one-clock completion pulse. After the pulse, read data is available on the read-data output.

An access goes to the external bus in two cases. The first is when the external-memory configuration bit is set. The second is when a pointer-mode address is equal to or greater than the on-chip RAM size (the roll-over). During on-chip accesses the external pins stay exactly as they were and no strobe moves. The block also holds a bank of two 16-bit data pointers. A pointer is loaded through a load port, and a select input picks which pointer is loaded, shown and used.

The sequencer is a single state machine.
- Idle, on a request that routes internally, goes to the on-chip path: IntAccess, then IntCapture, then Finish.
- Idle, on a request that routes externally, goes to the bus path: AddrPhase, then LatchPhase, then SetupPhase, then StrobePhase (held for the parameterized strobe length), then HoldPhase, then Finish.
- Finish always returns to Idle.

Top module: `xmem_seq`

## Requirements
- R1: After reset, rd_n and wr_n are 1, ale, lo_oe, done and busy are 0, and both data pointers are 0x0000.
- R2: When ext_cfg is 1, every access uses the external bus, whatever the mode or address.
- R3: When ext_cfg is 0, a pointer-mode access with address >= INT_SIZE (default 0x0300) uses the external bus. A pointer-mode access below INT_SIZE uses on-chip RAM. A register-indirect access always uses on-chip RAM.
- R4: An on-chip access pulses int_en for one clock, in the first cycle after acceptance. That pulse carries int_addr (the 8-bit index zero-extended in indirect mode), int_we equal to the write flag, and int_wdata. A read returns the int_rdata presented one clock later. Throughout the access, ale, lo_oe, rd_n low and wr_n low never occur, and lo_out and hi_out do not change.
- R5: On an external pointer-mode access, hi_out equals the pointer's upper byte for the whole cycle. lo_out carries the pointer's lower byte with lo_oe=1 in both the address and latch clocks.
- R6: On an external register-indirect access, lo_out carries the 8-bit index in the address and latch clocks, and hi_out keeps its previous value.
- R7: An external cycle goes through these clocks in order, counted from acceptance: ale high for exactly one clock (clock 1), then one latch clock, then one setup clock, then the strobe held low for STROBE_CLKS consecutive clocks (default 2), then a hold clock.
- R8: An external read drives only rd_n low. lo_oe is 0 from the setup clock through the hold clock. rd_data equals the lo_in value present in the last clock that rd_n is low.
- R9: An external write drives only wr_n low. lo_out equals the write data with lo_oe=1 from the setup clock through the hold clock, which is the clock after wr_n rises.
- R10: done is high for exactly one clock. This is clock 3 after acceptance for an on-chip access and clock 5+STROBE_CLKS for an external access.
- R11: ptr_load writes ptr_wdata into the pointer selected by aux_sel, which is bit 0 of the auxiliary control register (0 = first pointer, 1 = second). dptr_out shows the selected pointer, and pointer-mode accesses use it.
- R12: A request is accepted only while busy is 0. req_valid asserted during an access starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_ptr_mode | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit indirect |
| req_addr8 | input | 8 | Index for register-indirect mode |
| req_wdata | input | 8 | Store data |
| ext_cfg | input | 1 | Force all data accesses to the external bus |
| aux_sel | input | 1 | Pointer select (auxiliary control bit 0) |
| ptr_load | input | 1 | Load the selected pointer |
| ptr_wdata | input | 16 | Pointer load value |
| dptr_out | output | 16 | Currently selected pointer |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Load result |
| int_en | output | 1 | On-chip RAM access enable |
| int_we | output | 1 | On-chip RAM write enable |
| int_addr | output | 16 | On-chip RAM address |
| int_wdata | output | 8 | On-chip RAM write data |
| int_rdata | input | 8 | On-chip RAM read data, one clock after int_en |
| lo_in | input | 8 | Low bus byte as seen at the pins |
| lo_out | output | 8 | Low bus byte driven: address then data |
| lo_oe | output | 1 | Output enable for lo_out |
| hi_out | output | 8 | High address byte |
| ale | output | 1 | Address-latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench targets the routing boundary. It uses a pointer exactly at INT_SIZE and one just below it, and it runs indirect accesses with the configuration bit both clear and set. An off-by-one compare would send one of these the wrong way, and the access would show up on the wrong interface. It also checks that hi_out keeps the byte from an earlier pointer access through on-chip and indirect cycles; a design that drives or clears it would break paging. It drives a different lo_in byte on each strobe clock, so a read sampled one clock early or late returns the wrong byte. It watches lo_oe and lo_out around the write strobe, where dropping data at the strobe edge would fail the hold check. Finally, it holds req_valid high during a busy cycle, which catches a sequencer that restarts mid-access.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int LOW_W  = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INT_ACC,
        ST_INT_CAP,
        ST_ADDR,
        ST_LATCH,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_FIN
    } xst_e;

    typedef struct packed {
        logic              write;
        logic              ptr_mode;
        logic              is_ext;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xreq_t;

endpackage

// File: rtl/xmem_dptr.sv
module xmem_dptr
    import xmem_pkg::*;
#(
    parameter int NUM_PTR = 2,
    localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] cur
);

    logic [ADDR_W-1:0] bank [NUM_PTR];

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (load && (sel == SEL_W'(g))) begin
                bank[g] <= wdata;
            end
        end
    end

    assign cur = bank[sel];

endmodule

// File: rtl/xmem_route.sv
module xmem_route
    import xmem_pkg::*;
#(
    parameter int INT_SIZE = 768
) (
    input  logic              ext_cfg,
    input  logic              ptr_mode,
    input  logic [LOW_W-1:0]  addr8,
    input  logic [ADDR_W-1:0] dptr,
    output logic [ADDR_W-1:0] addr,
    output logic              is_ext
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(INT_SIZE);

    logic above;

    always_comb begin
        above  = ({1'b0, dptr} >= LIMIT);
        addr   = ptr_mode ? dptr : {{(ADDR_W-LOW_W){1'b0}}, addr8};
        is_ext = ext_cfg | (ptr_mode & above);
    end

endmodule

// File: rtl/xmem_fsm.sv
module xmem_fsm
    import xmem_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    localparam int CNT_W      = $clog2(STROBE_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xreq_t             req_in,
    input  logic [DATA_W-1:0] lo_in,
    input  logic [DATA_W-1:0] int_rdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [LOW_W-1:0]  lo_out,
    output logic              lo_oe,
    output logic [7:0]        hi_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              int_en,
    output logic              int_we,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CLKS - 1);

    xst_e              state, nxt;
    xreq_t             cur;
    logic [CNT_W-1:0]  cnt;
    logic [LOW_W-1:0]  lo_q;
    logic [7:0]        hi_q;
    logic [DATA_W-1:0] rd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = req_in.is_ext ? ST_ADDR : ST_INT_ACC;
            ST_INT_ACC: nxt = ST_INT_CAP;
            ST_INT_CAP: nxt = ST_FIN;
            ST_ADDR:    nxt = ST_LATCH;
            ST_LATCH:   nxt = ST_SETUP;
            ST_SETUP:   nxt = ST_STROBE;
            ST_STROBE:  if (cnt == LAST) nxt = ST_HOLD;
            ST_HOLD:    nxt = ST_FIN;
            ST_FIN:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // request capture, strobe counter, port and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur  <= '0;
            cnt  <= '0;
            lo_q <= '0;
            hi_q <= '0;
            rd_q <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                cur <= req_in;
                if (req_in.is_ext) begin
                    lo_q <= req_in.addr[LOW_W-1:0];
                    if (req_in.ptr_mode) hi_q <= req_in.addr[ADDR_W-1:LOW_W];
                end
            end
            if (state == ST_LATCH && cur.write) lo_q <= cur.wdata;
            cnt <= (state == ST_STROBE) ? cnt + 1'b1 : '0;
            if (state == ST_STROBE && cnt == LAST && !cur.write) rd_q <= lo_in;
            if (state == ST_INT_CAP && !cur.write) rd_q <= int_rdata;
        end
    end

    // output decode
    always_comb begin
        ale       = (state == ST_ADDR);
        lo_oe     = (state == ST_ADDR) || (state == ST_LATCH) ||
                    (cur.write && ((state == ST_SETUP) || (state == ST_STROBE) ||
                                   (state == ST_HOLD)));
        rd_n      = !((state == ST_STROBE) && !cur.write);
        wr_n      = !((state == ST_STROBE) && cur.write);
        int_en    = (state == ST_INT_ACC);
        int_we    = (state == ST_INT_ACC) && cur.write;
        int_addr  = cur.addr;
        int_wdata = cur.wdata;
        done      = (state == ST_FIN);
        busy      = (state != ST_IDLE);
        lo_out    = lo_q;
        hi_out    = hi_q;
        rd_data   = rd_q;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));                                            // R8
    AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT_ACC || state == ST_INT_CAP) |->
        (rd_n && wr_n && !ale && !lo_oe && $stable(lo_out) && $stable(hi_out))); // R4
    AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !lo_oe);                                             // R8
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (lo_oe && $stable(lo_out)));                   // R9
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                               // R10
    AST_ALE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);                                                 // R7
    AST_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> cur.is_ext);                                           // R2
    AST_HI_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !cur.ptr_mode) |-> $stable(hi_out));                   // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);                                     // R12

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int INT_SIZE    = 768,
    parameter int STROBE_CLKS = 2,
    parameter int NUM_PTR     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_ptr_mode,
    input  logic [7:0]             req_addr8,
    input  logic [7:0]             req_wdata,
    input  logic                   ext_cfg,
    input  logic [$clog2(NUM_PTR)-1:0] aux_sel,
    input  logic                   ptr_load,
    input  logic [15:0]            ptr_wdata,
    output logic [15:0]            dptr_out,
    output logic                   busy,
    output logic                   done,
    output logic [7:0]             rd_data,
    output logic                   int_en,
    output logic                   int_we,
    output logic [15:0]            int_addr,
    output logic [7:0]             int_wdata,
    input  logic [7:0]             int_rdata,
    input  logic [7:0]             lo_in,
    output logic [7:0]             lo_out,
    output logic                   lo_oe,
    output logic [7:0]             hi_out,
    output logic                   ale,
    output logic                   rd_n,
    output logic                   wr_n
);

    logic [ADDR_W-1:0] route_addr;
    logic              route_ext;
    logic              start;
    xreq_t             req;

    xmem_dptr #(.NUM_PTR(NUM_PTR)) u_dptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ptr_load),
        .sel   (aux_sel),
        .wdata (ptr_wdata),
        .cur   (dptr_out)
    );

    xmem_route #(.INT_SIZE(INT_SIZE)) u_route (
        .ext_cfg  (ext_cfg),
        .ptr_mode (req_ptr_mode),
        .addr8    (req_addr8),
        .dptr     (dptr_out),
        .addr     (route_addr),
        .is_ext   (route_ext)
    );

    always_comb begin
        start        = req_valid && !busy;
        req.write    = req_write;
        req.ptr_mode = req_ptr_mode;
        req.is_ext   = route_ext;
        req.addr     = route_addr;
        req.wdata    = req_wdata;
    end

    xmem_fsm #(.STROBE_CLKS(STROBE_CLKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_in    (req),
        .lo_in     (lo_in),
        .int_rdata (int_rdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .lo_out    (lo_out),
        .lo_oe     (lo_oe),
        .hi_out    (hi_out),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .int_en    (int_en),
        .int_we    (int_we),
        .int_addr  (int_addr),
        .int_wdata (int_wdata)
    );

endmodule

// File: tb/xmem_seq_bench.sv
module xmem_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int STB = 2;
    localparam int NS  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_ptr_mode = 1'b0;
    logic [7:0]  req_addr8 = '0, req_wdata = '0;
    logic        ext_cfg = 1'b0;
    logic [0:0]  aux_sel = '0;
    logic        ptr_load = 1'b0;
    logic [15:0] ptr_wdata = '0;
    logic [15:0] dptr_out;
    logic        busy, done;
    logic [7:0]  rd_data;
    logic        int_en, int_we;
    logic [15:0] int_addr;
    logic [7:0]  int_wdata;
    logic [7:0]  int_rdata = '0;
    logic [7:0]  lo_in = '0;
    logic [7:0]  lo_out, hi_out;
    logic        lo_oe, ale, rd_n, wr_n;

    int n_chk = 0;
    int n_fail = 0;

    logic       s_ale [NS], s_oe [NS], s_rd [NS], s_wr [NS], s_done [NS], s_ien [NS], s_iwe [NS];
    logic [7:0] s_lo [NS], s_hi [NS];
    logic [15:0] s_iaddr [NS];
    int n_samp;
    int done_idx;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (int_en) int_rdata <= int_addr[7:0] ^ 8'hA5;
    end

    xmem_seq u_xmem_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ptr_mode(req_ptr_mode), .req_addr8(req_addr8), .req_wdata(req_wdata),
        .ext_cfg(ext_cfg), .aux_sel(aux_sel), .ptr_load(ptr_load), .ptr_wdata(ptr_wdata),
        .dptr_out(dptr_out), .busy(busy), .done(done), .rd_data(rd_data),
        .int_en(int_en), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
        .int_rdata(int_rdata), .lo_in(lo_in), .lo_out(lo_out), .lo_oe(lo_oe),
        .hi_out(hi_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_ptr(input logic sel, input logic [15:0] v);
        @(negedge clk);
        aux_sel = sel; ptr_load = 1'b1; ptr_wdata = v;
        @(negedge clk);
        ptr_load = 1'b0;
    endtask

    task automatic run(input logic wr, input logic pm, input logic [7:0] a8,
                       input logic [7:0] wd, input logic [7:0] base);
        int k;
        bit seen;
        k = 0; seen = 0; n_samp = 0; done_idx = -1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_ptr_mode = pm; req_addr8 = a8; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            s_ale[i] = ale; s_oe[i] = lo_oe; s_rd[i] = rd_n; s_wr[i] = wr_n;
            s_done[i] = done; s_lo[i] = lo_out; s_hi[i] = hi_out;
            s_ien[i] = int_en; s_iwe[i] = int_we; s_iaddr[i] = int_addr;
            n_samp = i + 1;
            if (!rd_n) begin lo_in = base + 8'(k); k++; end
            if (seen) break;
            if (done) begin seen = 1; done_idx = i; end
        end
    endtask

    task automatic chk_ext(input logic wr, input logic [7:0] alo, input logic [7:0] ehi,
                           input logic [7:0] wd, input logic [7:0] base, input string tag);
        int nale, nstb, nbad, noe;
        nale = 0; nstb = 0; nbad = 0; noe = 0;
        for (int i = 0; i < n_samp; i++) begin
            if (s_ale[i]) nale++;
            if (!(wr ? s_wr[i] : s_rd[i])) begin
                nstb++;
                if (i < 3 || i > 2 + STB) nbad++;
            end
            if (!(wr ? s_rd[i] : s_wr[i])) nbad++;
        end
        chk(s_ale[0] && nale == 1, "R7", {tag, " ale one clock first"}, nale, 1);
        chk(nstb == STB && nbad == 0, wr ? "R9" : "R8", {tag, " strobe clocks"}, nstb, STB);
        chk(s_oe[0] && s_oe[1] && s_lo[0] == alo && s_lo[1] == alo, "R5",
            {tag, " low address phase"}, {s_lo[0], s_lo[1]}, {alo, alo});
        for (int i = 0; i < n_samp; i++)
            if (s_hi[i] != ehi) nbad++;
        chk(nbad == 0, "R6", {tag, " hi byte whole cycle"}, s_hi[3], ehi);
        for (int i = 2; i <= 3 + STB; i++)
            if (wr ? (s_oe[i] && s_lo[i] == wd) : !s_oe[i]) noe++;
        chk(noe == STB + 2, wr ? "R9" : "R8", {tag, " data phase drive"}, noe, STB + 2);
        chk(done_idx == 4 + STB && !s_done[n_samp-1], "R10", {tag, " done timing"}, done_idx, 4 + STB);
        if (!wr) chk(rd_data == base + 8'(STB - 1), "R8", {tag, " read sample"}, rd_data, base + 8'(STB - 1));
    endtask

    task automatic chk_int(input logic wr, input logic [15:0] ea, input logic [7:0] plo,
                           input logic [7:0] phi, input string tag);
        int nbad;
        nbad = 0;
        for (int i = 0; i < n_samp; i++)
            if (s_ale[i] || s_oe[i] || !s_rd[i] || !s_wr[i] || s_lo[i] != plo || s_hi[i] != phi) nbad++;
        chk(nbad == 0, "R4", {tag, " pins quiet"}, nbad, 0);
        chk(s_ien[0] && !s_ien[1] && s_iaddr[0] == ea && s_iwe[0] == wr, "R4",
            {tag, " ram port"}, s_iaddr[0], ea);
        chk(done_idx == 2 && !s_done[n_samp-1], "R10", {tag, " done timing"}, done_idx, 2);
        if (!wr) chk(rd_data == (ea[7:0] ^ 8'hA5), "R4", {tag, " read data"}, rd_data, ea[7:0] ^ 8'hA5);
    endtask

    task automatic t_reset();
        #1;
        chk(rd_n && wr_n && !ale && !lo_oe && !done && !busy, "R1", "strobes idle",
            {rd_n, wr_n, ale, lo_oe, done, busy}, 6'b110000);
        chk(dptr_out == 16'h0000, "R1", "pointer clear", dptr_out, 0);
    endtask

    task automatic t_ptrs();
        load_ptr(1'b0, 16'h1234);
        load_ptr(1'b1, 16'h0300);
        chk(dptr_out == 16'h0300, "R11", "second pointer", dptr_out, 16'h0300);
        @(negedge clk); aux_sel = 1'b0; #1;
        chk(dptr_out == 16'h1234, "R11", "first pointer kept", dptr_out, 16'h1234);
    endtask

    task automatic t_ext_ptr_read();
        ext_cfg = 1'b1; aux_sel = 1'b0;
        run(1'b0, 1'b1, 8'h00, 8'h00, 8'h40);
        chk_ext(1'b0, 8'h34, 8'h12, 8'h00, 8'h40, "R2 cfg read ptr0");
    endtask

    task automatic t_rollover_write();
        ext_cfg = 1'b0; aux_sel = 1'b1;
        run(1'b1, 1'b1, 8'h00, 8'hC3, 8'h00);
        chk_ext(1'b1, 8'h00, 8'h03, 8'hC3, 8'h00, "R3 boundary write ptr1");
    endtask

    task automatic t_int_below();
        load_ptr(1'b1, 16'h02FF);
        ext_cfg = 1'b0; aux_sel = 1'b1;
        run(1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
        chk_int(1'b0, 16'h02FF, 8'hC3, 8'h03, "R3 below size");
    endtask

    task automatic t_indirect_int();
        ext_cfg = 1'b0;
        run(1'b1, 1'b0, 8'hF0, 8'h77, 8'h00);
        chk_int(1'b1, 16'h00F0, 8'hC3, 8'h03, "R3 indirect internal");
        chk(int_wdata == 8'h77, "R4", "write data to ram", int_wdata, 8'h77);
    endtask

    task automatic t_indirect_ext();
        ext_cfg = 1'b1;
        run(1'b0, 1'b0, 8'h5C, 8'h00, 8'h90);
        chk_ext(1'b0, 8'h5C, 8'h03, 8'h00, 8'h90, "R6 indirect external");
    endtask

    task automatic t_busy_ignore();
        int ndone;
        ndone = 0;
        ext_cfg = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_ptr_mode = 1'b0; req_addr8 = 8'h11;
        @(negedge clk);
        if (done) ndone++;
        req_addr8 = 8'h22;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        req_valid = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        chk(ndone == 1 && !busy, "R12", "one access while held", ndone, 1);
    endtask

    initial begin
        #(5 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ptrs();
        t_ext_ptr_read();
        t_rollover_write();
        t_int_below();
        t_indirect_int();
        t_indirect_ext();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule